// File: doc/BRIEF.md
# Auto-Incrementing Work-RAM Access Port

This block gives a processor or transfer engine byte-wide write access to a large work RAM through four registers that sit in a small address window. A 17-bit pointer selects the RAM byte. Software loads the pointer one byte at a time, low byte first or in any order, then streams bytes into the data register. Each byte lands at the pointer, and the pointer then moves one byte forward. This makes it possible to fill long runs of RAM with a fixed target address on the bus.

Register decode looks only at the low 16 bits of the bus address, so the window is visible in every bank. The registers, as offsets from `REG_BASE` (default 0x2180), are: +0 data, +1 pointer bits [7:0], +2 pointer bits [15:8], +3 pointer bit 16 (taken from data bit 0). The block drives a registered RAM write port and contains a behavioural RAM array. That array has a direct inspection read port, `peek_addr`/`peek_data`. The array keeps the low `RAM_AW` bits of the pointer. A full-size build sets `RAM_AW` = 17, which gives 128 KiB. The default is a smaller model depth.

The write-port sequencer is a two-state machine. State ST_IDLE means no store is pending, and `ram_we` is low. State ST_STORE means a store is being presented, and `ram_we` is high. The transitions are:
- IDLE_TO_STORE is taken on a data-register write.
- STORE_TO_STORE is taken on a data-register write that follows another one directly.
- STORE_TO_IDLE is taken on any other cycle.
- IDLE_TO_IDLE is taken when no data write occurs.

Top module: `wram_access_port`

## Requirements
- R1: After reset the pointer is 0 and `ram_we` is low, so the first data write after reset stores at RAM address 0.
- R2: A bus write (`bus_we`=1) whose low 16 address bits equal `REG_BASE` makes `ram_we` high on the next cycle, with `ram_addr` equal to the pointer and `ram_wdata` equal to the written byte.
- R3: Each data write advances the pointer by exactly one, so data writes on consecutive cycles store to consecutive addresses, with carries crossing byte boundaries.
- R4: A write to `REG_BASE`+1 replaces pointer bits [7:0] with the data byte and keeps pointer bits [16:8].
- R5: A write to `REG_BASE`+2 replaces pointer bits [15:8] with the data byte and keeps the other pointer bits.
- R6: A write to `REG_BASE`+3 sets pointer bit 16 from data bit 0. The other data bits are ignored, and pointer bits [15:0] are kept.
- R7: Address bits [23:16] take no part in decode, so the window responds in every bank.
- R8: When the pointer is 0x1FFFF, a data write stores there and the pointer wraps to 0x00000.
- R9: A cycle with `bus_we` low, or a write outside the four-register window, neither changes the pointer nor raises `ram_we`.
- R10: A byte stored by the write port can be read on `peek_data` from the cycle after `ram_we`. Reset does not clear the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W (24) | Bus address |
| bus_data | input | DATA_W (8) | Bus write data |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | PTR_W (17) | RAM write address |
| ram_wdata | output | DATA_W (8) | RAM write data |
| peek_addr | input | RAM_AW (12) | Inspection read address into the RAM array |
| peek_data | output | DATA_W (8) | Inspection read data |

## Verification
A wrong pointer value is never shown directly. It shows up as a wrong `ram_addr` on the next data write, one cycle after that write is issued. For this reason every pointer-load test is followed by a data write that exposes the pointer. A wrong sequencer state shows as `ram_we` that is missing or stuck high one cycle after a bus write. A lost store, or a reset that clears memory, shows on `peek_data` one cycle after the store or at any later read.

// File: rtl/wram_port_pkg.sv
package wram_port_pkg;

    // Which window register a bus cycle targets
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_PLO,
        SEL_PMID,
        SEL_PTOP
    } reg_sel_e;

    // Write-port sequencer states
    typedef enum logic {
        ST_IDLE,
        ST_STORE
    } store_state_e;

endpackage

// File: rtl/wram_reg_decode.sv
module wram_reg_decode
    import wram_port_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter logic [15:0] REG_BASE = 16'h2180
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel
);
    localparam int WIN_REGS = 4;

    logic [15:0] offset;

    // Only the low 16 address bits take part: the window repeats in every bank
    assign offset = bus_addr[15:0] - REG_BASE;

    always_comb begin
        sel = SEL_NONE;
        if (bus_we && (offset < 16'(WIN_REGS))) begin
            unique case (offset[1:0])
                2'd0: sel = SEL_DATA;
                2'd1: sel = SEL_PLO;
                2'd2: sel = SEL_PMID;
                2'd3: sel = SEL_PTOP;
            endcase
        end
    end
endmodule

// File: rtl/wram_ptr_unit.sv
module wram_ptr_unit
    import wram_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] data,
    output logic [PTR_W-1:0]  ptr
);
    localparam int              TOP_LSB = 2 * DATA_W;
    localparam int              TOP_W   = PTR_W - TOP_LSB;
    localparam logic [PTR_W-1:0] ONE    = PTR_W'(1);

    logic [PTR_W-1:0] ptr_nx;

    always_comb begin
        ptr_nx = ptr;
        unique case (sel)
            SEL_DATA: ptr_nx = ptr + ONE;
            SEL_PLO:  ptr_nx[DATA_W-1:0] = data;
            SEL_PMID: ptr_nx[TOP_LSB-1:DATA_W] = data;
            SEL_PTOP: ptr_nx[PTR_W-1:TOP_LSB] = data[TOP_W-1:0];
            default:  ptr_nx = ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nx;
    end

    assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_DATA) |=> (ptr == $past(ptr) + ONE));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_DATA && ptr == '1) |=> (ptr == '0));

    assert_lo_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PLO) |=> (ptr[DATA_W-1:0] == $past(data)
                              && ptr[PTR_W-1:DATA_W] == $past(ptr[PTR_W-1:DATA_W])));

    assert_mid_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PMID) |=> (ptr[TOP_LSB-1:DATA_W] == $past(data)
                               && ptr[DATA_W-1:0] == $past(ptr[DATA_W-1:0])));

    assert_top_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PTOP) |=> (ptr[TOP_LSB-1:0] == $past(ptr[TOP_LSB-1:0])));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |=> $stable(ptr));
endmodule

// File: rtl/wram_store_fsm.sv
module wram_store_fsm
    import wram_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_sel_e          sel,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DATA_W-1:0] data,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);
    store_state_e state, state_nx;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = (sel == SEL_DATA) ? ST_STORE : ST_IDLE;
            ST_STORE: state_nx = (sel == SEL_DATA) ? ST_STORE : ST_IDLE;
        endcase
    end

    // State register with the captured store operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            state <= state_nx;
            if (sel == SEL_DATA) begin
                ram_addr  <= ptr;
                ram_wdata <= data;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        ram_we = 1'b0;
        unique case (state)
            ST_IDLE:  ram_we = 1'b0;
            ST_STORE: ram_we = 1'b1;
        endcase
    end

    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_DATA) |=> (ram_we && ram_addr == $past(ptr)
                               && ram_wdata == $past(data)));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != SEL_DATA) |=> !ram_we);
endmodule

// File: rtl/wram_array.sv
module wram_array #(
    parameter int DATA_W = 8,
    parameter int RAM_AW = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [RAM_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RAM_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // No reset: contents survive a block reset
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/wram_access_port.sv
module wram_access_port
    import wram_port_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter int          DATA_W   = 8,
    parameter int          PTR_W    = 17,
    parameter int          RAM_AW   = 12,
    parameter logic [15:0] REG_BASE = 16'h2180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [RAM_AW-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data
);
    reg_sel_e          sel;
    logic [PTR_W-1:0]  ptr;

    wram_reg_decode #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) u_dec (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .sel      (sel)
    );

    wram_ptr_unit #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .data  (bus_data),
        .ptr   (ptr)
    );

    wram_store_fsm #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .ptr       (ptr),
        .data      (bus_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    wram_array #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_addr[RAM_AW-1:0]),
        .wdata (ram_wdata),
        .raddr (peek_addr),
        .rdata (peek_data)
    );

    // R7: a write in a foreign bank to the data register still produces a store
    assert_any_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[15:0] == REG_BASE) |=> ram_we);
endmodule

// File: tb/sim_wram_access_port.sv
module sim_wram_access_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [23:0] bus_addr;
    logic [7:0]  bus_data;
    logic        ram_we;
    logic [16:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [11:0] peek_addr;
    logic [7:0]  peek_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wram_access_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

    // {we, addr[23:0], data[7:0], exp_we, exp_addr[16:0], exp_data[7:0]}
    localparam int NV = 14;
    localparam logic [58:0] VEC [NV] = '{
        {1'b1, 24'h002180, 8'hAA, 1'b1, 17'h00000, 8'hAA}, // R2
        {1'b1, 24'h7E2180, 8'hBB, 1'b1, 17'h00001, 8'hBB}, // R3 R7
        {1'b1, 24'h002181, 8'h34, 1'b0, 17'h00000, 8'h00}, // R4
        {1'b1, 24'h002182, 8'h12, 1'b0, 17'h00000, 8'h00}, // R5
        {1'b1, 24'h002180, 8'h01, 1'b1, 17'h01234, 8'h01}, // R5
        {1'b1, 24'h002183, 8'hFE, 1'b0, 17'h00000, 8'h00}, // R6
        {1'b1, 24'h002180, 8'h02, 1'b1, 17'h01235, 8'h02}, // R6
        {1'b1, 24'h002183, 8'h03, 1'b0, 17'h00000, 8'h00}, // R6
        {1'b1, 24'h002180, 8'h03, 1'b1, 17'h11236, 8'h03}, // R6
        {1'b0, 24'h002180, 8'h55, 1'b0, 17'h00000, 8'h00}, // R9
        {1'b1, 24'h002184, 8'h66, 1'b0, 17'h00000, 8'h00}, // R9
        {1'b1, 24'h002180, 8'h04, 1'b1, 17'h11237, 8'h04}, // R9
        {1'b1, 24'h3F2181, 8'hFF, 1'b0, 17'h00000, 8'h00}, // R4 R7
        {1'b1, 24'h002180, 8'h05, 1'b1, 17'h112FF, 8'h05}  // R3
    };
    localparam logic [23:0] TAG [NV] = '{
        "R2 ", "R3 ", "R4 ", "R5 ", "R5 ", "R6 ", "R6 ",
        "R6 ", "R6 ", "R9 ", "R9 ", "R9 ", "R4 ", "R3 "
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we   = 1'b1;
        bus_addr = a;
        bus_data = d;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_data  = '0;
        peek_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset we", 32'(ram_we), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_we   = VEC[i][58];
            bus_addr = VEC[i][57:34];
            bus_data = VEC[i][33:26];
            @(posedge clk);
            #1;
            check(string'(TAG[i]), 32'(ram_we), 32'(VEC[i][25]));
            if (VEC[i][25]) begin
                check(string'(TAG[i]), 32'(ram_addr), 32'(VEC[i][24:8]));
                check(string'(TAG[i]), 32'(ram_wdata), 32'(VEC[i][7:0]));
            end
            bus_we = 1'b0;
        end

        // R8: wrap at the top of the pointer range
        bus_write(24'h002181, 8'hFF);
        bus_write(24'h002182, 8'hFF);
        bus_write(24'h002183, 8'h01);
        bus_write(24'h002180, 8'hA5);
        check("R8 top store", 32'(ram_addr), 32'h1FFFF);
        bus_write(24'h002180, 8'h5A);
        check("R8 wrapped", 32'(ram_addr), 32'h00000);
        @(posedge clk);
        #1;
        check("R9 idle we", 32'(ram_we), 32'h0);

        // R10: stored bytes readable on the inspection port
        peek_addr = 12'h000;
        #1;
        check("R10 addr 0", 32'(peek_data), 32'h5A);
        peek_addr = 12'hFFF;
        #1;
        check("R10 top alias", 32'(peek_data), 32'hA5);
        peek_addr = 12'h001;
        #1;
        check("R10 addr 1", 32'(peek_data), 32'hBB);

        // R1 / R10: a second reset clears the pointer, not the RAM
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset again we", 32'(ram_we), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 kept over reset", 32'(peek_data), 32'hBB);
        bus_write(24'h002180, 8'h77);
        check("R1 pointer zero", 32'(ram_addr), 32'h00000);
        check("R1 data", 32'(ram_wdata), 32'h77);

        summary();
        $finish;
    end
endmodule